// File: doc/BRIEF.md
# Packed Floating-Point Magnitude Maximum Unit

This block is one SIMD datapath stage. It takes two 128-bit source vectors and a 32-bit instruction word. The instruction word selects the lane format (16-, 32- or 64-bit IEEE-754) and the vector width (64 or 128 bits). In each lane the unit keeps whichever of the two operands has the larger magnitude and writes it with the sign bit cleared. The outputs are registered one cycle after an issue strobe.

The unit recognises two instruction patterns. The first has a fixed 16-bit lane. In the second, one bit picks between 32-bit and 64-bit lanes. A 64-bit vector of 64-bit lanes is reserved and is rejected. So is any word that matches neither pattern. A rejected word raises the undefined flag and leaves the destination register as it was. The register-index fields of the word are not decoded here, because the register file is outside this block.

Top module: `fp_absmax_unit`

## Requirements
- R1: The 16-bit lane pattern is bit 31 = 0, bits 29..21 = 001110110 and bits 15..10 = 000111. Bit 30 (width bit) = 0 gives four lanes in bits 63..0, and bit 30 = 1 gives eight lanes over 127..0. Lane e occupies bits 16e+15..16e.
- R2: The 32/64-bit pattern is bit 31 = 0, bits 29..23 = 0011101, bit 21 = 1 and bits 15..10 = 110111. Bit 22 = 0 gives 32-bit lanes: two when bit 30 = 0 and four when bit 30 = 1. Bit 22 = 1 with bit 30 = 1 gives two 64-bit lanes. Lanes are packed upward from bit 0. Bits 20..16, 9..5 and 4..0 have no effect.
- R3: The second pattern with bit 22 = 1 and bit 30 = 0 sets undef_q = 1 and invop_q = 0, and leaves dst_q unchanged.
- R4: A word that matches neither pattern sets undef_q = 1 and invop_q = 0, and leaves dst_q unchanged.
- R5: Each lane result is the operand with the larger magnitude, with its sign bit forced to 0.
- R6: +0 and -0 compare equal and give +0. Infinity is larger than every finite value, and subnormals are compared exactly, with no flushing.
- R7: If either operand of an active lane is a NaN, the lane result is the default quiet NaN: 0x7E00, 0x7FC00000 or 0x7FF8000000000000.
- R8: invop_q = 1 when any active-lane operand is a signalling NaN (exponent all ones, fraction nonzero, fraction MSB 0). Operands in the inactive upper half of a 64-bit operation are ignored.
- R9: For a legal 64-bit-wide operation, dst_q bits 127..64 are written as 0.
- R10: Outputs update on the clock edge where issue_valid = 1 and hold while issue_valid = 0. After reset, dst_q, undef_q and invop_q are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Executes the presented word this cycle |
| instr_word | input | 32 | Instruction word |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| dst_q | output | 128 | Destination vector |
| undef_q | output | 1 | Last issued word was undefined |
| invop_q | output | 1 | Last issued operation saw a signalling NaN |

## Verification
The hardest case to reach is a signalling NaN placed where it must not count: in the upper half of a 64-bit-wide operation. There it must neither set the invalid flag nor leak into the zeroed upper result. The stimulus fills the inactive half with signalling NaNs and arbitrary patterns in both the 16-bit and 32-bit narrow forms, and separately places signalling NaNs in active lanes of every format. Rejected words are issued right after a legal result, so that a preserved destination can be told apart from one that was cleared.

// File: rtl/fp_absmax_pkg.sv
package fp_absmax_pkg;

  localparam int INSTR_W = 32;
  localparam int NUM_FMT = 3;

  typedef enum logic [1:0] {
    FMT_H = 2'd0,
    FMT_S = 2'd1,
    FMT_D = 2'd2
  } fmt_e;

  typedef struct packed {
    logic legal;
    logic wide;
    fmt_e fmt;
  } dec_t;

  function automatic int fmt_exp_w(int f);
    case (f)
      0:       return 5;
      1:       return 8;
      default: return 11;
    endcase
  endfunction

  function automatic int fmt_man_w(int f);
    case (f)
      0:       return 10;
      1:       return 23;
      default: return 52;
    endcase
  endfunction

endpackage

// File: rtl/fp_absmax_decode.sv
module fp_absmax_decode
  import fp_absmax_pkg::*;
(
  input  logic [INSTR_W-1:0] word_i,
  output dec_t               dec_o
);
  logic is_half, is_sd, sd_dbl, width_bit;

  always_comb begin
    width_bit = word_i[30];
    sd_dbl    = word_i[22];
    is_half   = (word_i[31] == 1'b0) && (word_i[29:21] == 9'b001110110) &&
                (word_i[15:10] == 6'b000111);
    is_sd     = (word_i[31] == 1'b0) && (word_i[29:23] == 7'b0011101) &&
                (word_i[21] == 1'b1) && (word_i[15:10] == 6'b110111);
    dec_o       = '0;
    dec_o.wide  = width_bit;
    if (is_half) begin
      dec_o.legal = 1'b1;
      dec_o.fmt   = FMT_H;
    end else if (is_sd) begin
      dec_o.fmt   = sd_dbl ? FMT_D : FMT_S;
      dec_o.legal = !(sd_dbl && !width_bit);
    end
  end
endmodule

// File: rtl/fp_absmax_lane.sv
module fp_absmax_lane #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W    = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         snan_o
);
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic [W-2:0] mag_a, mag_b;
  logic         nan_a, nan_b;

  always_comb begin
    mag_a  = a_i[W-2:0];
    mag_b  = b_i[W-2:0];
    nan_a  = (&a_i[W-2:MAN_W]) && (|a_i[MAN_W-1:0]);
    nan_b  = (&b_i[W-2:MAN_W]) && (|b_i[MAN_W-1:0]);
    snan_o = (nan_a && !a_i[MAN_W-1]) || (nan_b && !b_i[MAN_W-1]);
    if (nan_a || nan_b) res_o = QNAN;
    else                res_o = {1'b0, (mag_a >= mag_b) ? mag_a : mag_b};
  end
endmodule

// File: rtl/fp_absmax_bank.sv
module fp_absmax_bank #(
  parameter int VEC_W = 128,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int LW   = 1 + EXP_W + MAN_W,
  localparam int NL   = VEC_W / LW
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  output logic [VEC_W-1:0] res_o,
  output logic             snan_lo_o,
  output logic             snan_hi_o
);
  logic [NL-1:0] lane_snan;

  for (genvar e = 0; e < NL; e++) begin : g_lane
    fp_absmax_lane #(.EXP_W(EXP_W), .MAN_W(MAN_W)) lane_i (
      .a_i   (a_i[e*LW +: LW]),
      .b_i   (b_i[e*LW +: LW]),
      .res_o (res_o[e*LW +: LW]),
      .snan_o(lane_snan[e])
    );
  end

  assign snan_lo_o = |lane_snan[NL/2-1:0];
  assign snan_hi_o = |lane_snan[NL-1:NL/2];
endmodule

// File: rtl/fp_absmax_unit.sv
module fp_absmax_unit
  import fp_absmax_pkg::*;
#(
  parameter int VEC_W = 128,
  localparam int HALF_W = VEC_W / 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue_valid,
  input  logic [INSTR_W-1:0] instr_word,
  input  logic [VEC_W-1:0]   src_a,
  input  logic [VEC_W-1:0]   src_b,
  output logic [VEC_W-1:0]   dst_q,
  output logic               undef_q,
  output logic               invop_q
);
  logic             rst_s1, rst_sync_n;
  dec_t             dec;
  logic [VEC_W-1:0] bank_res [NUM_FMT];
  logic [NUM_FMT-1:0] snan_lo, snan_hi;
  logic [VEC_W-1:0] dst_d, sel_res;
  logic             undef_d, invop_d, dst_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  fp_absmax_decode dec_i (.word_i(instr_word), .dec_o(dec));

  for (genvar f = 0; f < NUM_FMT; f++) begin : g_fmt
    fp_absmax_bank #(
      .VEC_W(VEC_W), .EXP_W(fmt_exp_w(f)), .MAN_W(fmt_man_w(f))
    ) bank_i (
      .a_i      (src_a),
      .b_i      (src_b),
      .res_o    (bank_res[f]),
      .snan_lo_o(snan_lo[f]),
      .snan_hi_o(snan_hi[f])
    );
  end

  always_comb begin
    sel_res = bank_res[dec.fmt];
    undef_d = !dec.legal;
    invop_d = dec.legal && (snan_lo[dec.fmt] || (dec.wide && snan_hi[dec.fmt]));
    dst_en  = issue_valid && dec.legal;
    dst_d   = dec.wide ? sel_res : {{HALF_W{1'b0}}, sel_res[HALF_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q   <= '0;
      undef_q <= 1'b0;
      invop_q <= 1'b0;
    end else if (!rst_sync_n) begin
      dst_q   <= '0;
      undef_q <= 1'b0;
      invop_q <= 1'b0;
    end else begin
      if (dst_en)      dst_q   <= dst_d;
      if (issue_valid) undef_q <= undef_d;
      if (issue_valid) invop_q <= invop_d;
    end
  end

  // R3: reserved double-lane narrow word seen from the raw bits
  p_reserved_flag_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue_valid && instr_word[31] == 1'b0 && instr_word[29:21] == 9'b001110111 &&
     instr_word[15:10] == 6'b110111 && !instr_word[30]) |=> undef_q);

  p_undef_keep_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue_valid && !dec.legal) |=> $stable(dst_q));

  p_sign_clear_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue_valid && dec.legal) |=> (!dst_q[VEC_W-1] && !dst_q[HALF_W-1]));

  p_flag_excl_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    invop_q |-> !undef_q);

  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue_valid && dec.legal && !dec.wide) |=> (dst_q[VEC_W-1:HALF_W] == '0));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !issue_valid |=> ($stable(dst_q) && $stable(undef_q) && $stable(invop_q)));

endmodule

// File: tb/fp_absmax_unit_tb_top.sv
module fp_absmax_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         issue_valid;
  logic [31:0]  instr_word;
  logic [127:0] src_a, src_b;
  logic [127:0] dst_q;
  logic         undef_q, invop_q;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  fp_absmax_unit dut_i (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr_word(instr_word),
    .src_a(src_a), .src_b(src_b), .dst_q(dst_q), .undef_q(undef_q), .invop_q(invop_q)
  );

  typedef struct packed {
    logic [31:0]  ins;
    logic [127:0] a;
    logic [127:0] b;
    logic [127:0] e;
    logic         u;
    logic         i;
  } vec_t;

  localparam int NV = 11;
  // rows: 0 8H R1/R5/R6, 1 4H R1/R7/R8/R9, 2 4S R2/R7/R8, 3 2S R2/R8/R9,
  // 4 2D R2/R8, 5 reserved R3, 6 unmatched R4, 7 2D fields R2/R6,
  // 8 4S quiet NaN R7, 9 8H sNaN R8, 10 2S subnormal R6
  localparam vec_t TBL [NV] = '{
    '{32'h4EC01C00,
      128'h4200_FBFF_3800_0001_7C00_8000_C000_3C00,
      128'h4200_7BFF_C400_8002_FC00_0000_3C00_BC00,
      128'h4200_7BFF_4400_0002_7C00_0000_4000_3C00, 1'b0, 1'b0},
    '{32'h0EC01C00,
      128'h7C01_7C01_7C01_7C01_7E00_3555_C000_0400,
      128'h0000_0000_0000_0000_3C00_B556_4000_8400,
      128'h0000_0000_0000_0000_7E00_3556_4000_0400, 1'b0, 1'b0},
    '{32'h4EA0DC00,
      128'hFF800000_80000000_7F800001_3F800000,
      128'h7F7FFFFF_00000000_00000000_C0000000,
      128'h7F800000_00000000_7FC00000_40000000, 1'b0, 1'b1},
    '{32'h0EA0DC00,
      128'h7F800001_7F800001_7FC00000_BF800000,
      128'h12345678_9ABCDEF0_7F800000_3F800001,
      128'h00000000_00000000_7FC00000_3F800001, 1'b0, 1'b0},
    '{32'h4EE0DC00,
      128'h0000000000000001_BFF0000000000000,
      128'h7FF0000000000001_3FE0000000000000,
      128'h7FF8000000000000_3FF0000000000000, 1'b0, 1'b1},
    '{32'h0EE0DC00,
      128'h1111111111111111_2222222222222222,
      128'h3333333333333333_4444444444444444,
      128'h7FF8000000000000_3FF0000000000000, 1'b1, 1'b0},
    '{32'h4EE0FC00,
      128'h1111111111111111_2222222222222222,
      128'h3333333333333333_4444444444444444,
      128'h7FF8000000000000_3FF0000000000000, 1'b1, 1'b0},
    '{32'h4EFFDFFF,
      128'hFFF0000000000000_8000000000000000,
      128'h7FEFFFFFFFFFFFFF_0000000000000000,
      128'h7FF0000000000000_0000000000000000, 1'b0, 1'b0},
    '{32'h4EA0DC00,
      128'h00000000_00000000_00000000_7FC12345,
      128'h00000000_00000000_00000000_00000000,
      128'h00000000_00000000_00000000_7FC00000, 1'b0, 1'b0},
    '{32'h4EC01C00,
      128'hFC01_0000_0000_0000_0000_0000_0000_0000,
      128'h0000_0000_0000_0000_0000_0000_0000_0000,
      128'h7E00_0000_0000_0000_0000_0000_0000_0000, 1'b0, 1'b1},
    '{32'h0EA0DC00,
      128'hFFFFFFFF_FFFFFFFF_80000001_007FFFFF,
      128'h00000000_00000000_00000002_80800000,
      128'h00000000_00000000_00000002_00800000, 1'b0, 1'b0}
  };

  function automatic string row_req(int r);
    case (r)
      0: return "R1/R5/R6";
      1: return "R1/R7/R8/R9";
      2: return "R2/R7/R8";
      3: return "R2/R8/R9";
      4: return "R2/R8";
      5: return "R3";
      6: return "R4";
      7: return "R2/R6";
      8: return "R7";
      9: return "R8";
      default: return "R6/R9";
    endcase
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    issue_valid = 1'b1;
    instr_word  = w;
    src_a       = a;
    src_b       = b;
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n       = 1'b0;
    issue_valid = 1'b0;
    instr_word  = '0;
    src_a       = '0;
    src_b       = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset dst", dst_q, '0);
    chk("R10 reset flags", {126'b0, undef_q, invop_q}, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int r = 0; r < NV; r++) begin
      issue(TBL[r].ins, TBL[r].a, TBL[r].b);
      chk({row_req(r), " dst"}, dst_q, TBL[r].e);
      chk({row_req(r), " undef"}, {127'b0, undef_q}, {127'b0, TBL[r].u});
      chk({row_req(r), " invop"}, {127'b0, invop_q}, {127'b0, TBL[r].i});
    end

    // R10: no issue, changed inputs, outputs hold
    @(negedge clk);
    instr_word = 32'h4EC01C00;
    src_a      = {8{16'h4000}};
    src_b      = '0;
    @(negedge clk);
    @(negedge clk);
    chk("R10 hold dst", dst_q, TBL[NV-1].e);
    chk("R10 hold flags", {126'b0, undef_q, invop_q}, '0);

    // R3 after a 16-bit result: narrow double word keeps dst
    issue(32'h4EC01C00, {8{16'hC200}}, {8{16'h0001}});
    chk("R5 8H neg", dst_q, {8{16'h4200}});
    issue(32'h0EE0DC00, '0, '0);
    chk("R3 keep dst", dst_q, {8{16'h4200}});
    chk("R3 undef", {127'b0, undef_q}, {127'b0, 1'b1});

    // R8: sNaN in active lane of 4H gives flag, flag clears on next legal op
    issue(32'h0EC01C00, {112'b0, 16'h7C01}, '0);
    chk("R8 4H snan dst", dst_q, {112'b0, 16'h7E00});
    chk("R8 4H snan flag", {127'b0, invop_q}, {127'b0, 1'b1});
    issue(32'h4EA0DC00, '0, '0);
    chk("R8 flag clears", {127'b0, invop_q}, '0);

    // R10: reset mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 mid reset", {dst_q[125:0], undef_q, invop_q}, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule